// File: doc/BRIEF.md
# Two-Line Character Display Command Model

This block is a synthesizable behavioural model of the command side of a two-line character display controller. A bus master presents one access per cycle: a valid strobe, a register-select bit (0 = instruction/status, 1 = data), a read/write bit (0 = write, 1 = read) and a byte. The model keeps an 80-byte display data RAM arranged as two lines of 40 columns, a 64-byte character generator RAM, a shared 7-bit address counter, a display shift offset, the entry, display and function flags, and a busy flag that stays high for a programmable number of cycles after each accepted operation.

Instruction bytes are decoded by the position of their highest set bit, so lower "don't care" bits never change which instruction runs. The address counter follows the two-line wrap rules and the entry direction, and data writes can scroll the whole display when auto-shift is enabled. Status reads return the busy flag with the address counter; data reads return RAM contents. The intended use is as a checker target for logic that drives such a display bus.

Top module: `chr_disp_ctl`

## Requirements
- R1: With select=0 and write, the instruction is chosen by the highest set bit of the byte: bit 7 set-display-address, bit 6 set-glyph-address, bit 5 function set, bit 4 cursor/display shift, bit 3 display control, bit 2 entry mode, bit 1 home, bit 0 clear; lower bits act only as that instruction's operands.
- R2: Clear (0x01) fills all 80 display RAM bytes with 0x20, sets the address counter to 0 with the display RAM selected, sets the shift offset to 0, forces `entry_inc` to 1 and leaves `entry_shift` unchanged.
- R3: Home (0x02/0x03) sets the address counter to 0 with the display RAM selected and the offset to 0, and leaves display RAM contents unchanged.
- R4: After each accepted data write or data read the address counter moves by one, up when `entry_inc`=1 and down otherwise; in glyph RAM it wraps modulo 64.
- R5: Entry mode byte bit 1 sets `entry_inc`, bit 0 sets `entry_shift`; with `entry_shift`=1 a display RAM data write moves the offset one step left (offset+1) when `entry_inc`=1 and right (offset-1) otherwise; data reads and glyph RAM writes never move it.
- R6: Shift instruction bits 3:2 = 00 moves the address counter down, 01 up, 10 moves the offset left (+1), 11 right (-1), leaving the counter unchanged; the offset stays in 0..39 and wraps at both ends.
- R7: In display RAM, line 1 is 0x00–0x27 and line 2 is 0x40–0x67; stepping up passes 0x27→0x40 and 0x67→0x00, stepping down passes 0x40→0x27 and 0x00→0x67.
- R8: Set-display-address loads bits 6:0 into the counter and selects display RAM; set-glyph-address loads bits 5:0 and selects glyph RAM; data accesses target the RAM selected last.
- R9: A status read (select=0, read) is always served: one cycle later `rd_valid`=1 with bit 7 = busy as seen at the request and bits 6:0 = address counter; it changes no state.
- R10: An accepted write or data read sets busy for `BUSY_SHORT` cycles, or `BUSY_LONG` for clear and home; writes and data reads offered while busy are dropped with no effect.
- R11: A data read returns one cycle later the byte stored at the address counter of the selected RAM.
- R12: Display control bits 2:0 appear on `disp_ctl`, function set bits 4:2 on `func_cfg`; after reset the counter is 0, display RAM holds 0x20, glyph RAM 0x00, offset 0, `entry_inc`=1 and all other flags 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe for this cycle |
| bus_rs | input | 1 | Register select: 0 instruction/status, 1 data |
| bus_rw | input | 1 | 0 write, 1 read |
| bus_wdata | input | 8 | Instruction or data byte |
| busy | output | 1 | Busy flag |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read result |
| disp_ofs | output | $clog2(COLS) | Display shift offset |
| entry_inc | output | 1 | Counter direction, 1 = up |
| entry_shift | output | 1 | Auto display shift enable |
| disp_ctl | output | 3 | Display, cursor, blink enables |
| func_cfg | output | 3 | Bus width, line count, font bits |

## Verification
The bench builds the block with the 40-column default and shortens the busy windows to 3 and 6 cycles, so that dropped accesses during busy, status reads that catch busy high, and the long clear/home window are all hit within a few cycles. With the real column count both line-wrap corners and the offset wrap at 39/0 are reached, and the glyph address 0x3F reaches its modulo-64 wrap.

// File: rtl/chr_disp_pkg.sv
package chr_disp_pkg;
  typedef enum logic [3:0] {
    OP_NONE   = 4'd0,
    OP_CLEAR  = 4'd1,
    OP_HOME   = 4'd2,
    OP_ENTRY  = 4'd3,
    OP_DCTL   = 4'd4,
    OP_SHIFT  = 4'd5,
    OP_FUNC   = 4'd6,
    OP_CGADDR = 4'd7,
    OP_DDADDR = 4'd8
  } op_e;

  localparam int AC_W   = 7;
  localparam int LINE_B = 6;   // counter bit that selects line 2
  localparam logic [7:0] BLANK = 8'h20;
endpackage

// File: rtl/chr_cmd_decode.sv
module chr_cmd_decode
  import chr_disp_pkg::*;
(
  input  logic [7:0] code,
  output op_e        op
);
  // Highest set bit wins: scan upward, later hits overwrite.
  always_comb begin
    op = OP_NONE;
    for (int i = 0; i < 8; i++) begin
      if (code[i]) op = op_e'(4'(i + 1));
    end
  end
endmodule

// File: rtl/chr_addr_unit.sv
module chr_addr_unit
  import chr_disp_pkg::*;
#(
  parameter int COLS  = 40,
  localparam int OFS_W = $clog2(COLS)
) (
  input  logic [AC_W-1:0]  ac_in,
  input  logic             sel_dd,
  input  logic             up,
  output logic [AC_W-1:0]  ac_step,
  input  logic [OFS_W-1:0] ofs_in,
  input  logic             left,
  output logic [OFS_W-1:0] ofs_step
);
  localparam logic [AC_W-1:0]  LAST1 = AC_W'(COLS - 1);
  localparam logic [AC_W-1:0]  FIRST2 = AC_W'(1 << LINE_B);
  localparam logic [AC_W-1:0]  LAST2 = FIRST2 | LAST1;
  localparam logic [OFS_W-1:0] OFS_MAX = OFS_W'(COLS - 1);

  always_comb begin
    if (!sel_dd) begin
      ac_step = {1'b0, (up ? ac_in[LINE_B-1:0] + 1'b1 : ac_in[LINE_B-1:0] - 1'b1)};
    end else if (up) begin
      if (ac_in == LAST1)      ac_step = FIRST2;
      else if (ac_in == LAST2) ac_step = '0;
      else                     ac_step = ac_in + 1'b1;
    end else begin
      if (ac_in == '0)          ac_step = LAST2;
      else if (ac_in == FIRST2) ac_step = LAST1;
      else                      ac_step = ac_in - 1'b1;
    end
  end

  always_comb begin
    if (left) ofs_step = (ofs_in == OFS_MAX) ? '0 : ofs_in + 1'b1;
    else      ofs_step = (ofs_in == '0) ? OFS_MAX : ofs_in - 1'b1;
  end
endmodule

// File: rtl/chr_busy_timer.sv
module chr_busy_timer #(
  parameter int BUSY_SHORT = 4,
  parameter int BUSY_LONG  = 12,
  localparam int CW = $clog2(BUSY_LONG + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic long_sel,
  output logic busy
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = start || (cnt_q != '0);
    if (start) cnt_d = long_sel ? CW'(BUSY_LONG) : CW'(BUSY_SHORT);
    else       cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/chr_disp_ctl.sv
module chr_disp_ctl
  import chr_disp_pkg::*;
#(
  parameter int COLS       = 40,
  parameter int CG_DEPTH   = 64,
  parameter int BUSY_SHORT = 4,
  parameter int BUSY_LONG  = 12,
  localparam int OFS_W     = $clog2(COLS),
  localparam int DD_DEPTH  = 2 * COLS,
  localparam int DD_IW     = $clog2(DD_DEPTH),
  localparam int CG_AW     = $clog2(CG_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid,
  input  logic             bus_rs,
  input  logic             bus_rw,
  input  logic [7:0]       bus_wdata,
  output logic             busy,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic [OFS_W-1:0] disp_ofs,
  output logic             entry_inc,
  output logic             entry_shift,
  output logic [2:0]       disp_ctl,
  output logic [2:0]       func_cfg
);
  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  // State
  logic [AC_W-1:0]  ac_q, ac_d;
  logic             sel_dd_q, sel_dd_d;
  logic [OFS_W-1:0] ofs_q, ofs_d;
  logic             inc_q, inc_d, shen_q, shen_d;
  logic [2:0]       dctl_q, dctl_d, fcfg_q, fcfg_d;
  logic             rdv_q, rdv_d;
  logic [7:0]       rdd_q, rdd_d;
  logic [7:0]       dd_mem [DD_DEPTH];
  logic [7:0]       cg_mem [CG_DEPTH];

  // Access classification
  logic is_stat, acc, is_cmd, is_dwr, is_drd;
  always_comb begin
    is_stat = bus_valid && !bus_rs && bus_rw;
    acc     = bus_valid && !busy && !is_stat;
    is_cmd  = acc && !bus_rs && !bus_rw;
    is_dwr  = acc && bus_rs && !bus_rw;
    is_drd  = acc && bus_rs && bus_rw;
  end

  op_e op;
  chr_cmd_decode u_dec (.code(bus_wdata), .op(op));

  logic do_clear, do_home, do_shift;
  always_comb begin
    do_clear = is_cmd && (op == OP_CLEAR);
    do_home  = is_cmd && (op == OP_HOME);
    do_shift = is_cmd && (op == OP_SHIFT);
  end

  // Address stepping
  logic             step_up, ofs_left;
  logic [AC_W-1:0]  ac_step;
  logic [OFS_W-1:0] ofs_step;
  always_comb begin
    step_up  = do_shift ? bus_wdata[2] : inc_q;
    ofs_left = do_shift ? !bus_wdata[2] : inc_q;
  end

  chr_addr_unit #(.COLS(COLS)) u_addr (
    .ac_in   (ac_q),
    .sel_dd  (sel_dd_q),
    .up      (step_up),
    .ac_step (ac_step),
    .ofs_in  (ofs_q),
    .left    (ofs_left),
    .ofs_step(ofs_step)
  );

  chr_busy_timer #(.BUSY_SHORT(BUSY_SHORT), .BUSY_LONG(BUSY_LONG)) u_busy (
    .clk     (clk),
    .rst_n   (rst_ni),
    .start   (acc),
    .long_sel(do_clear || do_home),
    .busy    (busy)
  );

  // RAM addressing
  logic [DD_IW-1:0] dd_idx;
  logic             dd_ok;
  logic [CG_AW-1:0] cg_idx;
  logic [7:0]       dd_rd;
  always_comb begin
    dd_ok  = (ac_q[LINE_B-1:0] < LINE_B'(COLS));
    dd_idx = ac_q[LINE_B] ? DD_IW'(COLS) + DD_IW'(ac_q[LINE_B-1:0])
                          : DD_IW'(ac_q[LINE_B-1:0]);
    cg_idx = CG_AW'(ac_q[LINE_B-1:0]);
    dd_rd  = dd_ok ? dd_mem[dd_idx] : BLANK;
  end

  // Next state
  always_comb begin
    ac_d     = ac_q;
    sel_dd_d = sel_dd_q;
    ofs_d    = ofs_q;
    inc_d    = inc_q;
    shen_d   = shen_q;
    dctl_d   = dctl_q;
    fcfg_d   = fcfg_q;
    if (is_cmd) begin
      unique case (op)
        OP_CLEAR: begin
          ac_d = '0; sel_dd_d = 1'b1; ofs_d = '0; inc_d = 1'b1;
        end
        OP_HOME: begin
          ac_d = '0; sel_dd_d = 1'b1; ofs_d = '0;
        end
        OP_ENTRY: begin
          inc_d = bus_wdata[1]; shen_d = bus_wdata[0];
        end
        OP_DCTL:  dctl_d = bus_wdata[2:0];
        OP_SHIFT: begin
          if (bus_wdata[3]) ofs_d = ofs_step;
          else              ac_d  = ac_step;
        end
        OP_FUNC:  fcfg_d = bus_wdata[4:2];
        OP_CGADDR: begin
          ac_d = {1'b0, bus_wdata[5:0]}; sel_dd_d = 1'b0;
        end
        OP_DDADDR: begin
          ac_d = bus_wdata[6:0]; sel_dd_d = 1'b1;
        end
        default: ;
      endcase
    end
    if (is_dwr) begin
      ac_d = ac_step;
      if (sel_dd_q && shen_q) ofs_d = ofs_step;
    end
    if (is_drd) ac_d = ac_step;
  end

  always_comb begin
    rdv_d = is_stat || is_drd;
    if (is_stat)       rdd_d = {busy, ac_q};
    else if (is_drd)   rdd_d = sel_dd_q ? dd_rd : cg_mem[cg_idx];
    else               rdd_d = rdd_q;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ac_q     <= '0;
      sel_dd_q <= 1'b1;
      ofs_q    <= '0;
      inc_q    <= 1'b1;
      shen_q   <= 1'b0;
      dctl_q   <= '0;
      fcfg_q   <= '0;
      rdv_q    <= 1'b0;
      rdd_q    <= '0;
    end else begin
      ac_q     <= ac_d;
      sel_dd_q <= sel_dd_d;
      ofs_q    <= ofs_d;
      inc_q    <= inc_d;
      shen_q   <= shen_d;
      dctl_q   <= dctl_d;
      fcfg_q   <= fcfg_d;
      rdv_q    <= rdv_d;
      if (rdv_d) rdd_q <= rdd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DD_DEPTH; i++) dd_mem[i] <= BLANK;
    end else if (do_clear) begin
      for (int i = 0; i < DD_DEPTH; i++) dd_mem[i] <= BLANK;
    end else if (is_dwr && sel_dd_q && dd_ok) begin
      dd_mem[dd_idx] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < CG_DEPTH; i++) cg_mem[i] <= '0;
    end else if (is_dwr && !sel_dd_q) begin
      cg_mem[cg_idx] <= bus_wdata;
    end
  end

  assign rd_valid    = rdv_q;
  assign rd_data     = rdd_q;
  assign disp_ofs    = ofs_q;
  assign entry_inc   = inc_q;
  assign entry_shift = shen_q;
  assign disp_ctl    = dctl_q;
  assign func_cfg    = fcfg_q;
endmodule

// File: rtl/chr_disp_chk.sv
module chr_disp_chk #(
  parameter int COLS  = 40,
  localparam int OFS_W = $clog2(COLS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_valid,
  input logic             bus_rs,
  input logic             bus_rw,
  input logic [7:0]       bus_wdata,
  input logic             busy,
  input logic             rd_valid,
  input logic             rd_busy,
  input logic [OFS_W-1:0] disp_ofs,
  input logic             entry_inc,
  input logic             entry_shift,
  input logic [2:0]       disp_ctl,
  input logic [2:0]       func_cfg
);
  assert_busy_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !busy && !(!bus_rs && bus_rw)) |=> busy);

  assert_drop_when_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && busy && !(!bus_rs && bus_rw)) |=>
      ($stable(disp_ofs) && $stable(entry_inc) && $stable(entry_shift) &&
       $stable(disp_ctl) && $stable(func_cfg) && !rd_valid));

  assert_status_format_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_rs && bus_rw) |=> (rd_valid && (rd_busy == $past(busy))));

  assert_read_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(bus_valid && bus_rw));

  assert_offset_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    disp_ofs < OFS_W'(COLS));

  assert_clear_effect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !busy && !bus_rs && !bus_rw && bus_wdata == 8'h01) |=>
      (disp_ofs == '0 && entry_inc && $stable(entry_shift)));

  // Leading-one decode picks display control whatever bits 2:0 hold (R1).
  assert_dctl_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !busy && !bus_rs && !bus_rw && bus_wdata[7:3] == 5'b00001) |=>
      (disp_ctl == $past(bus_wdata[2:0])));
endmodule

bind chr_disp_ctl chr_disp_chk #(.COLS(COLS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_ni),
  .bus_valid  (bus_valid),
  .bus_rs     (bus_rs),
  .bus_rw     (bus_rw),
  .bus_wdata  (bus_wdata),
  .busy       (busy),
  .rd_valid   (rd_valid),
  .rd_busy    (rd_data[7]),
  .disp_ofs   (disp_ofs),
  .entry_inc  (entry_inc),
  .entry_shift(entry_shift),
  .disp_ctl   (disp_ctl),
  .func_cfg   (func_cfg)
);

// File: tb/sim_chr_disp_ctl.sv
module sim_chr_disp_ctl;
  localparam int COLS = 40;
  localparam int BS   = 3;
  localparam int BL   = 6;
  localparam int OW   = $clog2(COLS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_rs = 1'b0, bus_rw = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic busy, rd_valid, entry_inc, entry_shift;
  logic [7:0] rd_data;
  logic [OW-1:0] disp_ofs;
  logic [2:0] disp_ctl, func_cfg;

  always #4 clk = ~clk;

  chr_disp_ctl #(.COLS(COLS), .CG_DEPTH(64), .BUSY_SHORT(BS), .BUSY_LONG(BL)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_rs(bus_rs),
    .bus_rw(bus_rw), .bus_wdata(bus_wdata), .busy(busy), .rd_valid(rd_valid),
    .rd_data(rd_data), .disp_ofs(disp_ofs), .entry_inc(entry_inc),
    .entry_shift(entry_shift), .disp_ctl(disp_ctl), .func_cfg(func_cfg)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  string cur = "R12";

  // Reference model state
  int dd [2*COLS];
  int cg [64];
  int m_ac, m_ofs, m_inc, m_sh, m_dctl, m_fcfg, m_seldd, m_bcnt, m_rdv, m_rdd;

  function automatic int m_step(int a, int up, int seldd);
    if (!seldd) return up ? (a + 1) % 64 : (a + 63) % 64;
    if (up) begin
      if (a == COLS - 1) return 64;
      if (a == 64 + COLS - 1) return 0;
      return a + 1;
    end
    if (a == 0) return 64 + COLS - 1;
    if (a == 64) return COLS - 1;
    return a - 1;
  endfunction

  function automatic int m_ofs_move(int o, int left);
    return left ? (o + 1) % COLS : (o + COLS - 1) % COLS;
  endfunction

  function automatic int m_dd_read(int a);
    if ((a % 64) >= COLS) return 32;
    return dd[(a >= 64 ? COLS : 0) + (a % 64)];
  endfunction

  task automatic m_init();
    foreach (dd[i]) dd[i] = 32;
    foreach (cg[i]) cg[i] = 0;
    m_ac = 0; m_ofs = 0; m_inc = 1; m_sh = 0; m_dctl = 0; m_fcfg = 0;
    m_seldd = 1; m_bcnt = 0; m_rdv = 0; m_rdd = 0;
  endtask

  task automatic m_apply(bit v, bit rs, bit rw, logic [7:0] d);
    bit stat, acc;
    int top;
    bit lng;
    stat = v && !rs && rw;
    acc  = v && (m_bcnt == 0) && !stat;
    lng  = 0;
    m_rdv = 0;
    if (stat) begin
      m_rdv = 1;
      m_rdd = ((m_bcnt != 0) ? 128 : 0) + m_ac;
    end
    if (acc && !rs && !rw) begin
      top = -1;
      for (int b = 7; b >= 0; b--) if (top < 0 && d[b]) top = b;
      case (top)
        0: begin foreach (dd[i]) dd[i] = 32; m_ac = 0; m_seldd = 1; m_ofs = 0; m_inc = 1; lng = 1; end
        1: begin m_ac = 0; m_seldd = 1; m_ofs = 0; lng = 1; end
        2: begin m_inc = d[1]; m_sh = d[0]; end
        3: m_dctl = d[2:0];
        4: if (d[3]) m_ofs = m_ofs_move(m_ofs, !d[2]);
           else      m_ac = m_step(m_ac, d[2], m_seldd);
        5: m_fcfg = d[4:2];
        6: begin m_ac = d[5:0]; m_seldd = 0; end
        7: begin m_ac = d[6:0]; m_seldd = 1; end
        default: ;
      endcase
    end
    if (acc && rs && !rw) begin
      if (m_seldd) begin
        if ((m_ac % 64) < COLS) dd[(m_ac >= 64 ? COLS : 0) + (m_ac % 64)] = d;
        if (m_sh) m_ofs = m_ofs_move(m_ofs, m_inc);
      end else cg[m_ac % 64] = d;
      m_ac = m_step(m_ac, m_inc, m_seldd);
    end
    if (acc && rs && rw) begin
      m_rdv = 1;
      m_rdd = m_seldd ? m_dd_read(m_ac) : cg[m_ac % 64];
      m_ac = m_step(m_ac, m_inc, m_seldd);
    end
    if (acc) m_bcnt = lng ? BL : BS;
    else if (m_bcnt > 0) m_bcnt--;
  endtask

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("R10", "busy", busy, m_bcnt != 0);
    chk("R6", "disp_ofs", disp_ofs, m_ofs);
    chk("R5", "entry_inc", entry_inc, m_inc);
    chk("R5", "entry_shift", entry_shift, m_sh);
    chk("R12", "disp_ctl", disp_ctl, m_dctl);
    chk("R12", "func_cfg", func_cfg, m_fcfg);
    chk("R9", "rd_valid", rd_valid, m_rdv);
    if (m_rdv) chk(cur, "rd_data", rd_data, m_rdd);
  endtask

  // One cycle: compare at the falling edge, then drive and advance the model.
  task automatic cyc(bit v, bit rs, bit rw, logic [7:0] d);
    @(negedge clk);
    compare();
    bus_valid = v; bus_rs = rs; bus_rw = rw; bus_wdata = d;
    m_apply(v, rs, rw, d);
  endtask

  task automatic settle();
    cyc(0, 0, 0, 8'h00);
    while (m_bcnt != 0) cyc(0, 0, 0, 8'h00);
  endtask

  task automatic cmd(logic [7:0] d);  cyc(1, 0, 0, d); settle(); endtask
  task automatic wr(logic [7:0] d);   cyc(1, 1, 0, d); settle(); endtask
  task automatic rd();                cyc(1, 1, 1, 8'h00); settle(); endtask
  task automatic st();                cyc(1, 0, 1, 8'h00); cyc(0, 0, 0, 8'h00); endtask

  initial begin
    m_init();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) cyc(0, 0, 0, 8'h00);

    cur = "R12"; st(); rd();            // reset state: AC 0, blank RAM
    cur = "R1";
    cmd(8'h0F); cmd(8'h0A); cmd(8'h3B); cmd(8'h27); cmd(8'h06);
    cur = "R8"; cmd(8'h85); wr(8'h41); wr(8'h42);
    cur = "R4"; st();
    cur = "R11"; cmd(8'h85); rd(); rd(); st();
    cur = "R7";
    cmd(8'hA6); wr(8'h31); wr(8'h32); wr(8'h33); st();
    cmd(8'hE7); wr(8'h34); st();
    cmd(8'h04); cmd(8'hC0); wr(8'h35); st();
    cmd(8'h80); wr(8'h36); st(); rd(); st();
    cmd(8'h06); cmd(8'hC0); rd(); rd(); st();
    cur = "R4";
    cmd(8'h7F); wr(8'h11); wr(8'h12); st();
    cmd(8'h7F); rd(); rd(); st();
    cmd(8'h04); cmd(8'h40); rd(); st();
    cur = "R5";
    cmd(8'h07); cmd(8'h80); wr(8'h58); wr(8'h59);
    cmd(8'h45); wr(8'h5A); rd();
    cmd(8'h83); rd();
    cmd(8'h05); cmd(8'h80); wr(8'h5B); wr(8'h5C); wr(8'h5D); st();
    cur = "R6";
    cmd(8'h06); cmd(8'h80);
    cmd(8'h10); st(); cmd(8'h14); st(); cmd(8'h17); st();
    cmd(8'h18); cmd(8'h1B); cmd(8'h1C); cmd(8'h1C); cmd(8'h1F); st();
    cur = "R3";
    cmd(8'h03); st(); rd(); rd();
    cmd(8'h1C); cmd(8'h02); st();
    cur = "R10";
    cyc(1, 0, 0, 8'h02);           // long busy
    cyc(1, 0, 1, 8'h00);           // status while busy
    cyc(1, 0, 0, 8'h0C);           // dropped
    cyc(1, 1, 0, 8'h77);           // dropped
    cyc(1, 1, 1, 8'h00);           // dropped
    settle(); st(); rd();
    cyc(1, 0, 0, 8'h0C); cyc(1, 0, 0, 8'h08); settle();
    cyc(1, 1, 0, 8'h61); cyc(1, 0, 1, 8'h00); cyc(1, 0, 1, 8'h00); settle();
    cur = "R2";
    cmd(8'h07); cmd(8'h80); wr(8'h50);
    cmd(8'h01); st();
    cmd(8'h80); rd(); cmd(8'hC5); rd(); cmd(8'hE7); rd();
    cmd(8'h05); cmd(8'h01); st();
    repeat (3) cyc(0, 0, 0, 8'h00);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got running expected done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule